// File: doc/BRIEF.md
# Looped Frame-Buffer DMA Channel

This block is the address and count engine behind one audio stream. Two playback streams and one record stream each use one copy of it. It holds a frame base address, a frame count word and a sample count word. The frame count word locates the stream inside a circular buffer in memory. The buffer is measured in 32-bit longwords, and a 2-bit byte offset (the leftover) records a position that does not fall on a longword boundary. The sample count word counts down samples, scaled by the sample format, until the next interrupt.

When the downstream side offers a transfer budget, the channel computes a memory address and a byte length. The length is the budget cut down to what the buffer and the sample countdown allow. The channel presents them as a request and holds the request until a done reply reports how many bytes were actually moved. It then advances the longword index, the leftover offset and the sample countdown. When a sample block completes exactly, it pulses an interrupt request. The memory bus and the data path are outside the block, so only the request and the reply cross its edge.

Top module: `frame_dma_chan`

## Requirements
- R1: After a synchronous active-low reset, the frame base, frame count word, sample count word and leftover are zero, and `req_valid` and `irq` are low.
- R2: Register writes are selected by `wr_sel`:
  - 0 loads the frame base.
  - 1 loads the whole frame count word (current longword index in bits 31:16, buffer size minus one in bits 15:0) and clears the leftover.
  - 2 loads only the reload count in bits 15:0 of the sample count word, keeping the current count in bits 31:16.
  - 3 changes nothing.
- R3: The byte shift is `fmt[0] + fmt[1]`, where bit 0 means stereo and bit 1 means 16-bit. The offered budget is first rounded down to a multiple of `1 << shift`. A rounded budget of zero starts no request.
- R4: The request length is the minimum of three values:
  - the rounded budget;
  - the bytes left, `4*(size - index + 1) + leftover`, taken as 0 when index > size;
  - the bytes due, `(current + 1) << shift`.
- R5: The request address is `base + 4*index + leftover`.
- R6: A request starts only when `enable` is 1 and the effective pause is 0. When `HAS_PAUSE` is 0 the pause input is ignored.
- R7: Once raised, `req_valid`, `req_addr` and `req_len` stay unchanged until the cycle in which `done_valid` is sampled. `req_valid` is low in the cycle after that.
- R8: If the bytes moved equal the bytes due, the current count is loaded from the reload count. In that case `irq` is high for exactly the one cycle after the done cycle.
- R9: Otherwise the current count becomes `(due - moved - 1) >> shift`, and `irq` stays low.
- R10: With `loop_sel` = 0 (looping), the index advances by `(moved + leftover) >> 2`, and the leftover becomes `(moved + leftover) & 3`. An index that would exceed size wraps to 0.
- R11: With `loop_sel` = 1, the frame count word is left unchanged on completion, while the leftover and the sample count still update.
- R12: A frame count write in the same cycle as a done reply takes the written value and leaves the leftover at 0, while the sample count still updates from the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel run enable |
| pause | input | 1 | Pause (ignored when HAS_PAUSE = 0) |
| loop_sel | input | 1 | 0 = looping buffer |
| fmt | input | 2 | Sample format: bit0 stereo, bit1 16-bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 base, 1 frame count, 2 sample count) |
| wr_data | input | 32 | Register write data |
| budget_valid | input | 1 | Budget offer strobe |
| budget_bytes | input | 19 | Offered byte budget |
| req_valid | output | 1 | Transfer request pending |
| req_addr | output | 32 | Request start address |
| req_len | output | 19 | Request byte length |
| done_valid | input | 1 | Transfer completed |
| done_bytes | input | 19 | Bytes actually moved (not above req_len) |
| irq | output | 1 | One-cycle sample-block interrupt request |
| frame_base_o | output | 32 | Frame base address |
| frame_cnt_o | output | 32 | Frame count word {index, size} |
| samp_cnt_o | output | 32 | Sample count word {current, reload} |
| leftover_o | output | 2 | Byte offset within the current longword |

## Verification
The done reply and a software write to the frame count or sample count can land in the same clock edge. Both update fields that overlap or depend on each other. The bench provokes this in directed cases and in about a tenth of its random transactions by raising `wr_en` in the same cycle as `done_valid`. It judges the result against a model that applies the completion first and the write second: the written frame word and a zero leftover win, and the sample countdown still follows the reply. Random budgets, formats, buffer sizes and partial byte counts also drive the index across the wrap point and past exact sample-block boundaries.

// File: rtl/fdc_pkg.sv
// Shared types and helpers for the frame-buffer DMA channel.
package fdc_pkg;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_FRAME  = 2'd1,
        SEL_SAMPLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } xfer_state_e;

    // Byte shift per sample: one for stereo plus one for 16-bit.
    function automatic logic [1:0] fmt_shift(input logic [1:0] fmt);
        return {1'b0, fmt[0]} + {1'b0, fmt[1]};
    endfunction

endpackage

// File: rtl/fdc_grant.sv
// Combinational grant calculator.
// Derives the request address, the bytes due before the next interrupt and
// the granted length from the stored position and the offered budget.
// Assumes the index and size fields come straight from the register file.
module fdc_grant
    import fdc_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int ADDR_W = 32,
    localparam int LEN_W  = CNT_W + 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic [CNT_W-1:0]  size_i,
    input  logic [CNT_W-1:0]  cur_i,
    input  logic [1:0]        lo_i,
    input  logic [1:0]        fmt_i,
    input  logic [LEN_W-1:0]  budget_i,
    output logic [LEN_W-1:0]  grant_o,
    output logic [LEN_W-1:0]  due_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        shift_o
);

    logic [LEN_W-1:0] mask;
    logic [LEN_W-1:0] budget_r;
    logic [LEN_W-1:0] left;
    logic [LEN_W-1:0] min_a;

    // Grant is the smallest of rounded budget, buffer room and bytes due.
    always_comb begin
        shift_o  = fmt_shift(fmt_i);
        mask     = {LEN_W{1'b1}} << shift_o;
        budget_r = budget_i & mask;
        if (idx_i > size_i)
            left = '0;
        else
            left = ((LEN_W'(size_i) - LEN_W'(idx_i) + LEN_W'(1)) << 2) + LEN_W'(lo_i);
        due_o   = (LEN_W'(cur_i) + LEN_W'(1)) << shift_o;
        min_a   = (budget_r < left) ? budget_r : left;
        grant_o = (min_a < due_o) ? min_a : due_o;
        addr_o  = base_i + (ADDR_W'(idx_i) << 2) + ADDR_W'(lo_i);
    end

endmodule

// File: rtl/fdc_xfer_ctrl.sv
// Transfer sequencer.
// Latches one request per accepted budget, holds it until the done reply,
// then computes the new countdown, index and leftover and pulses the irq.
// Assumes done_bytes never exceeds the granted length.
module fdc_xfer_ctrl
    import fdc_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int ADDR_W = 32,
    localparam int LEN_W  = CNT_W + 3,
    localparam int SUM_W  = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  grant_i,
    input  logic [LEN_W-1:0]  due_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        shift_i,
    input  logic              done_valid_i,
    input  logic [LEN_W-1:0]  done_bytes_i,
    input  logic              loop_sel_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic [CNT_W-1:0]  size_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [1:0]        lo_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [LEN_W-1:0]  req_len_o,
    output logic              irq_o,
    output logic              upd_en_o,
    output logic              upd_idx_we_o,
    output logic [CNT_W-1:0]  upd_cur_o,
    output logic [CNT_W-1:0]  upd_idx_o,
    output logic [1:0]        upd_lo_o
);

    xfer_state_e      state_q;
    logic [LEN_W-1:0] due_q;
    logic [1:0]       sh_q;
    logic             irq_q;
    logic             exact;
    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] tot;
    logic [SUM_W-1:0] idx_sum;

    // Completion arithmetic on the latched due count and shift.
    always_comb begin
        exact        = (done_bytes_i == due_q);
        rem          = due_q - done_bytes_i - LEN_W'(1);
        upd_cur_o    = exact ? reload_i : CNT_W'(rem >> sh_q);
        tot          = done_bytes_i + LEN_W'(lo_i);
        idx_sum      = SUM_W'(idx_i) + SUM_W'(tot >> 2);
        upd_idx_o    = (idx_sum <= SUM_W'(size_i)) ? idx_sum[CNT_W-1:0] : '0;
        upd_lo_o     = tot[1:0];
        upd_en_o     = (state_q == ST_BUSY) && done_valid_i;
        upd_idx_we_o = upd_en_o && !loop_sel_i;
    end

    // Request latch, handshake state and one-cycle interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_addr_o <= '0;
            req_len_o  <= '0;
            due_q      <= '0;
            sh_q       <= '0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= upd_en_o && exact;
            case (state_q)
                ST_IDLE: begin
                    if (start_i && (grant_i != '0)) begin
                        state_q    <= ST_BUSY;
                        req_addr_o <= addr_i;
                        req_len_o  <= grant_i;
                        due_q      <= due_i;
                        sh_q       <= shift_i;
                    end
                end
                default: begin
                    if (done_valid_i)
                        state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_valid_o = (state_q == ST_BUSY);
    assign irq_o       = irq_q;

endmodule

// File: rtl/fdc_regs.sv
// Channel register file.
// Holds base, index, size, current and reload counts and the leftover.
// Completion updates are applied first; a software write in the same
// cycle overrides the fields it names.
module fdc_regs
    import fdc_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int ADDR_W = 32,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              upd_en_i,
    input  logic              upd_idx_we_i,
    input  logic [CNT_W-1:0]  upd_cur_i,
    input  logic [CNT_W-1:0]  upd_idx_i,
    input  logic [1:0]        upd_lo_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic [CNT_W-1:0]  size_o,
    output logic [CNT_W-1:0]  cur_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [1:0]        lo_o
);

    // State update: completion first, then software write with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o   <= '0;
            idx_o    <= '0;
            size_o   <= '0;
            cur_o    <= '0;
            reload_o <= '0;
            lo_o     <= '0;
        end else begin
            if (upd_en_i) begin
                cur_o <= upd_cur_i;
                lo_o  <= upd_lo_i;
                if (upd_idx_we_i)
                    idx_o <= upd_idx_i;
            end
            if (wr_en_i) begin
                case (reg_sel_e'(wr_sel_i))
                    SEL_BASE:   base_o <= ADDR_W'(wr_data_i);
                    SEL_FRAME: begin
                        idx_o  <= wr_data_i[DATA_W-1:CNT_W];
                        size_o <= wr_data_i[CNT_W-1:0];
                        lo_o   <= 2'b00;
                    end
                    SEL_SAMPLE: reload_o <= wr_data_i[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/frame_dma_chan.sv
// Looped frame-buffer DMA channel top.
// Wires the register file, grant calculator and transfer sequencer.
// HAS_PAUSE = 0 builds the record variant, whose pause input has no effect.
module frame_dma_chan
    import fdc_pkg::*;
#(
    parameter  int CNT_W     = 16,
    parameter  int ADDR_W    = 32,
    parameter  bit HAS_PAUSE = 1'b1,
    localparam int LEN_W     = CNT_W + 3,
    localparam int DATA_W    = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pause,
    input  logic              loop_sel,
    input  logic [1:0]        fmt,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              budget_valid,
    input  logic [LEN_W-1:0]  budget_bytes,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    input  logic              done_valid,
    input  logic [LEN_W-1:0]  done_bytes,
    output logic              irq,
    output logic [ADDR_W-1:0] frame_base_o,
    output logic [DATA_W-1:0] frame_cnt_o,
    output logic [DATA_W-1:0] samp_cnt_o,
    output logic [1:0]        leftover_o
);

    logic [CNT_W-1:0]  idx, size, cur, reload;
    logic [1:0]        lo, shift;
    logic [ADDR_W-1:0] base, addr;
    logic [LEN_W-1:0]  grant, due;
    logic              pause_eff, start;
    logic              upd_en, upd_idx_we;
    logic [CNT_W-1:0]  upd_cur, upd_idx;
    logic [1:0]        upd_lo;

    // Pause variant selection.
    generate
        if (HAS_PAUSE) begin : g_pause
            assign pause_eff = pause;
        end else begin : g_no_pause
            assign pause_eff = pause & 1'b0;
        end
    endgenerate

    assign start = budget_valid && enable && !pause_eff;

    fdc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .upd_en_i(upd_en), .upd_idx_we_i(upd_idx_we),
        .upd_cur_i(upd_cur), .upd_idx_i(upd_idx), .upd_lo_i(upd_lo),
        .base_o(base), .idx_o(idx), .size_o(size),
        .cur_o(cur), .reload_o(reload), .lo_o(lo)
    );

    fdc_grant #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_grant (
        .base_i(base), .idx_i(idx), .size_i(size), .cur_i(cur),
        .lo_i(lo), .fmt_i(fmt), .budget_i(budget_bytes),
        .grant_o(grant), .due_o(due), .addr_o(addr), .shift_o(shift)
    );

    fdc_xfer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .grant_i(grant), .due_i(due), .addr_i(addr), .shift_i(shift),
        .done_valid_i(done_valid), .done_bytes_i(done_bytes),
        .loop_sel_i(loop_sel), .idx_i(idx), .size_i(size),
        .reload_i(reload), .lo_i(lo),
        .req_valid_o(req_valid), .req_addr_o(req_addr), .req_len_o(req_len),
        .irq_o(irq), .upd_en_o(upd_en), .upd_idx_we_o(upd_idx_we),
        .upd_cur_o(upd_cur), .upd_idx_o(upd_idx), .upd_lo_o(upd_lo)
    );

    assign frame_base_o = base;
    assign frame_cnt_o  = {idx, size};
    assign samp_cnt_o   = {cur, reload};
    assign leftover_o   = lo;

endmodule

// File: rtl/fdc_checker.sv
// Protocol and state checks for frame_dma_chan, bound into every instance.
// Assumes the bench keeps done_bytes within the granted length.
module fdc_checker #(
    parameter  int CNT_W     = 16,
    parameter  int ADDR_W    = 32,
    parameter  bit HAS_PAUSE = 1'b1,
    localparam int LEN_W     = CNT_W + 3,
    localparam int DATA_W    = 2 * CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              pause,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic              done_valid,
    input logic              irq,
    input logic [DATA_W-1:0] frame_cnt_o,
    input logic [1:0]        leftover_o
);

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !done_valid) |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R7

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && done_valid) |=> !req_valid); // R7

    AST_NO_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0)); // R3

    AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(enable && !(pause && HAS_PAUSE))); // R6

    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(req_valid && done_valid)); // R8

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_FRAME_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (frame_cnt_o == $past(wr_data) && leftover_o == 2'b00)); // R12

endmodule

bind frame_dma_chan fdc_checker #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .HAS_PAUSE(HAS_PAUSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pause(pause),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .done_valid(done_valid), .irq(irq),
    .frame_cnt_o(frame_cnt_o), .leftover_o(leftover_o)
);

// File: tb/frame_dma_chan_tb.sv
// Self-checking bench: directed corners plus seeded random transactions
// against a reference model built from the requirements.
module frame_dma_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, pause = 1'b0, loop_sel = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        budget_valid = 1'b0;
    logic [18:0] budget_bytes = '0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [18:0] req_len;
    logic        done_valid = 1'b0;
    logic [18:0] done_bytes = '0;
    logic        irq;
    logic [31:0] frame_base_o, frame_cnt_o, samp_cnt_o;
    logic [1:0]  leftover_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model state
    int m_base, m_idx, m_size, m_cur, m_rel, m_lo;

    always #4 clk = ~clk;

    frame_dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pause(pause),
        .loop_sel(loop_sel), .fmt(fmt), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .budget_valid(budget_valid), .budget_bytes(budget_bytes),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .done_valid(done_valid), .done_bytes(done_bytes), .irq(irq),
        .frame_base_o(frame_base_o), .frame_cnt_o(frame_cnt_o),
        .samp_cnt_o(samp_cnt_o), .leftover_o(leftover_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int f_shift(input int f);
        return (f & 1) + ((f >> 1) & 1);
    endfunction

    function automatic int f_min(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int f_due(input int f);
        return (m_cur + 1) << f_shift(f);
    endfunction

    function automatic int f_grant(input int budget, input int f);
        int sh, br, left;
        sh = f_shift(f);
        br = (budget >> sh) << sh;
        left = (m_idx > m_size) ? 0 : (((m_size - m_idx + 1) << 2) + m_lo);
        return f_min(br, f_min(left, f_due(f)));
    endfunction

    task automatic check_state(input string req);
        chk(frame_cnt_o == {m_idx[15:0], m_size[15:0]}, req, "frame_cnt",
            frame_cnt_o, {m_idx[15:0], m_size[15:0]});
        chk(samp_cnt_o == {m_cur[15:0], m_rel[15:0]}, req, "samp_cnt",
            samp_cnt_o, {m_cur[15:0], m_rel[15:0]});
        chk(leftover_o == m_lo[1:0], req, "leftover", leftover_o, m_lo);
    endtask

    task automatic reg_write(input int sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            0: m_base = data;
            1: begin m_idx = int'(data[31:16]); m_size = int'(data[15:0]); m_lo = 0; end
            2: m_rel = int'(data[15:0]);
            default: ;
        endcase
    endtask

    // One budget offer; moved < 0 means move the full grant.
    task automatic xact(input int budget, input int moved_req, input int wait_cyc,
                        input bit collide, input logic [31:0] cdata, input string req);
        int len, due, sh, moved, tot, isum;
        bit exact;
        int exp_addr;
        len = f_grant(budget, int'(fmt));
        due = f_due(int'(fmt));
        sh = f_shift(int'(fmt));
        exp_addr = m_base + (m_idx << 2) + m_lo;
        @(negedge clk);
        budget_valid = 1'b1; budget_bytes = budget[18:0];
        @(negedge clk);
        budget_valid = 1'b0;
        if (!enable || (pause && 1'b1)) len = 0;
        if (len == 0) begin
            chk(req_valid == 1'b0, req, "no request", req_valid, 0);
            return;
        end
        chk(req_valid == 1'b1, req, "req_valid", req_valid, 1);
        chk(req_len == len[18:0], "R4", "req_len", req_len, len);
        chk(req_addr == exp_addr, "R5", "req_addr", req_addr, exp_addr);
        for (int w = 0; w < wait_cyc; w++) begin
            @(negedge clk);
            chk(req_valid && req_len == len[18:0] && req_addr == exp_addr,
                "R7", "held request", req_len, len);
        end
        moved = (moved_req < 0 || moved_req > len) ? len : moved_req;
        done_valid = 1'b1; done_bytes = moved[18:0];
        if (collide) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = cdata; end
        @(negedge clk);
        done_valid = 1'b0; wr_en = 1'b0;
        exact = (moved == due);
        m_cur = exact ? m_rel : ((due - moved - 1) >> sh);
        tot = moved + m_lo;
        if (!loop_sel) begin
            isum = m_idx + (tot >> 2);
            m_idx = (isum <= m_size) ? isum : 0;
        end
        m_lo = tot & 3;
        if (collide) begin m_idx = int'(cdata[31:16]); m_size = int'(cdata[15:0]); m_lo = 0; end
        chk(irq == exact, exact ? "R8" : "R9", "irq", irq, exact);
        chk(req_valid == 1'b0, "R7", "req dropped", req_valid, 0);
        check_state(req);
        @(negedge clk);
        chk(irq == 1'b0, "R8", "irq one cycle", irq, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1370));
        m_base = 0; m_idx = 0; m_size = 0; m_cur = 0; m_rel = 0; m_lo = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(frame_base_o == 0, "R1", "base", frame_base_o, 0);
        check_state("R1");
        chk(req_valid == 0 && irq == 0, "R1", "req/irq", {req_valid, irq}, 0);

        // R2 register writes, select 3 ignored
        reg_write(0, 32'h1000_0000);
        chk(frame_base_o == 32'h1000_0000, "R2", "base", frame_base_o, 32'h1000_0000);
        reg_write(1, 32'h0002_0007);
        reg_write(2, 32'h0000_0003);
        check_state("R2");
        reg_write(3, 32'hFFFF_FFFF);
        check_state("R2");
        chk(frame_base_o == 32'h1000_0000, "R2", "sel3 ignored", frame_base_o, 32'h1000_0000);

        // R6 gating
        enable = 1'b0; fmt = 2'd0;
        xact(8, -1, 0, 0, 0, "R6");
        enable = 1'b1; pause = 1'b1;
        xact(8, -1, 0, 0, 0, "R6");
        pause = 1'b0;

        // R3 rounding to zero with 16-bit stereo
        fmt = 2'd3;
        xact(3, -1, 0, 0, 0, "R3");

        // R8 exact completion (cur 0, due 4 bytes)
        xact(100, -1, 2, 0, 0, "R8");
        // R9 partial transfer, cur = reload 3, due 16
        xact(100, 6, 0, 0, 0, "R9");
        // R10 wrap: index near end of buffer
        fmt = 2'd0;
        reg_write(1, 32'h0007_0007);
        reg_write(2, 32'h0000_00FF);
        xact(200, -1, 0, 0, 0, "R10");
        xact(200, 5, 1, 0, 0, "R10");
        // R11 non-looping keeps frame count
        loop_sel = 1'b1;
        xact(13, -1, 0, 0, 0, "R11");
        loop_sel = 1'b0;
        // R12 frame write collides with done
        xact(40, 7, 0, 1, 32'h0001_0009, "R12");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0) reg_write(1, {16'($urandom_range(0, 12)), 16'($urandom_range(0, 12))});
            else if (r == 1) reg_write(2, {16'($urandom), 16'($urandom_range(0, 20))});
            else if (r == 2) reg_write(0, $urandom);
            fmt = 2'($urandom_range(0, 3));
            loop_sel = ($urandom_range(0, 9) == 0);
            xact(int'($urandom_range(0, 120)),
                 ($urandom_range(0, 1) == 1) ? -1 : int'($urandom_range(0, 120)),
                 int'($urandom_range(0, 2)),
                 $urandom_range(0, 9) == 0,
                 {16'($urandom_range(0, 10)), 16'($urandom_range(0, 10))},
                 "R10");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule